// File: doc/BRIEF.md
# Dual-Channel Serial ADC Capture Controller

This block runs a two-channel serial analog-to-digital converter that samples both inputs at the same instant when its conversion strobe goes high. Each request starts a frame. The block first asks a shared serial bus for access and waits for a grant. It then pulses the strobe for one serial clock period and clocks in a 34-bit frame. From that frame it builds two signed 14-bit results and widens each one to a 16-bit word.

The converter returns the result of the *previous* strobe in each frame. The first frame after reset therefore carries stale data, and the block drops it without raising valid. A software-set sample period, with a floor computed from the system clock and the converter's top sample rate, limits how close together the strobes can be. A level start request captures one frame. A continuous request keeps capturing frames until it is cleared.

Top module: `dual_adc_capture`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) drives `sclk`, `conv`, `bus_req` and `valid` low and clears `ch0` and `ch1` to zero. A reset in the middle of a frame abandons that frame.
- R2: `bus_req` goes high when a request is accepted. `conv` and `sclk` stay low until `bus_gnt` is seen. `sclk` only rises after a cycle in which `bus_gnt` was high.
- R3: In each frame, `conv` is high for exactly CLK_DIV system cycles while `sclk` is low. Then follow 34 `sclk` pulses, each CLK_DIV cycles long, and `conv` is never high while `sclk` is high. `bus_req` drops after the last falling edge, with `sclk` low.
- R4: `sdo` is sampled at each rising edge of `sclk`. The edges are numbered 0 to 33 from the first edge after the strobe. `ch0` takes edges 2 to 15 and `ch1` takes edges 18 to 31, most significant bit first. The bits at edges 0, 1, 16, 17, 32 and 33 have no effect on either word.
- R5: Each 14-bit two's complement result is output sign-extended: bits 15 and 14 copy bit 13.
- R6: The first frame after reset never raises `valid` and leaves both words at zero. Every later frame presents the conversion that the previous strobe started.
- R7: `valid` is high for exactly one cycle. That cycle is the first cycle with `bus_req` low after the frame, and both words take their new values in it. At all other times both words hold their value.
- R8: Rising edges of `conv` are at least P = max(`period`, ceil(CLK_HZ/MAX_RATE_HZ)) cycles apart. In continuous mode, with a grant that answers in the same cycle, the spacing is exactly max(P, 35*CLK_DIV+2) cycles.
- R9: `start` is a level request that is taken only while the block is idle and the rate floor allows it. One accepted `start` yields exactly one frame. `continuous` repeats frames until it is cleared, and the frame in progress then completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Single-frame request (level, held until `bus_req` rises) |
| continuous | input | 1 | Back-to-back frame request |
| period | input | PER_W | Requested strobe spacing in system cycles |
| bus_gnt | input | 1 | Shared serial bus grant |
| sdo | input | 1 | Serial data from the converter |
| bus_req | output | 1 | Shared serial bus request |
| sclk | output | 1 | Serial clock to the converter |
| conv | output | 1 | Conversion strobe, active high |
| ch0 | output | OUT_W | Channel 0 sample, sign-extended |
| ch1 | output | OUT_W | Channel 1 sample, sign-extended |
| valid | output | 1 | One-cycle pulse when both words update |

## Verification
A converter model in the bench returns each strobe's analog pair one frame late. Several input patterns test the capture path:
- A mixed positive/negative pair shows whether the two slots are swapped or misaligned.
- Full-scale negative and positive codes test sign extension at both limits.
- Idle bits are driven first as ones and then as zeros, which exposes any leakage of gap bits into the words.

Holding the grant low separates the request from the clocking. Continuous runs with a period below and above the floor tell the clamp apart from the requested spacing. A reset in the middle of a frame shows that stale-frame discard is re-armed.

// File: rtl/adc_cap_pkg.sv
package adc_cap_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REQ,
        ST_CONV,
        ST_SHIFT
    } seq_state_e;

    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    // first serial edge index carrying data for channel ch
    function automatic int slot_first(input int ch, input int gap, input int dw);
        return gap + ch * (dw + gap);
    endfunction

endpackage

// File: rtl/adc_sclk_phase.sv
module adc_sclk_phase #(
    parameter int HALF   = 2,
    parameter int HALF_W = $clog2(HALF) + 1
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic half_done
);
    logic [HALF_W-1:0] cnt_d, cnt_q;

    always_comb begin
        half_done = run && (cnt_q == HALF_W'(HALF - 1));
        cnt_d     = cnt_q;
        if (!run || half_done) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/adc_rate_guard.sv
module adc_rate_guard #(
    parameter int PER_W      = 16,
    parameter int MIN_PERIOD = 134
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             strobe,
    input  logic [PER_W-1:0] period,
    output logic             ready
);
    localparam logic [PER_W-1:0] FLOOR = PER_W'(MIN_PERIOD);

    logic [PER_W-1:0] eff;
    logic [PER_W-1:0] timer_d, timer_q;

    // R8: spacing floor applied to the requested period
    always_comb begin
        eff   = (period < FLOOR) ? FLOOR : period;
        ready = (timer_q >= eff - 1'b1);
        if (strobe) begin
            timer_d = PER_W'(1);
        end else if (timer_q == '1) begin
            timer_d = timer_q;
        end else begin
            timer_d = timer_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            timer_q <= '1;
        end else begin
            timer_q <= timer_d;
        end
    end
endmodule

// File: rtl/adc_frame_shifter.sv
module adc_frame_shifter #(
    parameter int DATA_W    = 14,
    parameter int OUT_W     = 16,
    parameter int IDLE_BITS = 2,
    parameter int BIT_W     = 6
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cap,
    input  logic [BIT_W-1:0]         bit_idx,
    input  logic                     sdo,
    input  logic                     commit,
    output logic [1:0][OUT_W-1:0]    words
);
    localparam int EXT_W = OUT_W - DATA_W;

    for (genvar c = 0; c < 2; c++) begin : g_ch
        localparam int FIRST = adc_cap_pkg::slot_first(c, IDLE_BITS, DATA_W);
        localparam int LAST  = FIRST + DATA_W - 1;

        logic              in_slot;
        logic [DATA_W-1:0] sh_d, sh_q;
        logic [OUT_W-1:0]  word_d, word_q;

        // R4: only the channel's own slot shifts; gap bits fall through
        always_comb begin
            in_slot = (bit_idx >= BIT_W'(FIRST)) && (bit_idx <= BIT_W'(LAST));
            sh_d    = (cap && in_slot) ? {sh_q[DATA_W-2:0], sdo} : sh_q;
            // R5: replicate the sign bit into the upper bits
            word_d  = commit ? {{EXT_W{sh_q[DATA_W-1]}}, sh_q} : word_q;
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                sh_q   <= '0;
                word_q <= '0;
            end else begin
                sh_q   <= sh_d;
                word_q <= word_d;
            end
        end

        assign words[c] = word_q;
    end
endmodule

// File: rtl/dual_adc_capture.sv
module dual_adc_capture #(
    parameter int CLK_HZ      = 200_000_000,
    parameter int MAX_RATE_HZ = 1_500_000,
    parameter int CLK_DIV     = 4,
    parameter int DATA_W      = 14,
    parameter int OUT_W       = 16,
    parameter int IDLE_BITS   = 2,
    parameter int PER_W       = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             continuous,
    input  logic [PER_W-1:0] period,
    input  logic             bus_gnt,
    input  logic             sdo,
    output logic             bus_req,
    output logic             sclk,
    output logic             conv,
    output logic [OUT_W-1:0] ch0,
    output logic [OUT_W-1:0] ch1,
    output logic             valid
);
    import adc_cap_pkg::*;

    localparam int HALF       = CLK_DIV / 2;
    localparam int FRAME_BITS = 3 * IDLE_BITS + 2 * DATA_W;
    localparam int BIT_W      = $clog2(FRAME_BITS);
    localparam int MIN_PERIOD = ceil_div(CLK_HZ, MAX_RATE_HZ);

    typedef struct packed {
        seq_state_e       st;
        logic             phase;
        logic             sclk;
        logic [BIT_W-1:0] bit_idx;
        logic             discard;
        logic             valid;
    } seq_t;

    seq_t q, n;

    logic run, half_done, ready, strobe, cap, commit, commit_en;
    logic [1:0][OUT_W-1:0] words;

    assign run = bus_gnt && ((q.st == ST_CONV) || (q.st == ST_SHIFT));

    adc_sclk_phase #(
        .HALF (HALF)
    ) u_phase (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .half_done (half_done)
    );

    adc_rate_guard #(
        .PER_W      (PER_W),
        .MIN_PERIOD (MIN_PERIOD)
    ) u_rate (
        .clk    (clk),
        .rst    (rst),
        .strobe (strobe),
        .period (period),
        .ready  (ready)
    );

    always_comb begin
        n         = q;
        n.valid   = 1'b0;
        strobe    = 1'b0;
        cap       = 1'b0;
        commit    = 1'b0;
        case (q.st)
            ST_IDLE: begin
                // R9: level requests are taken only when the floor allows
                if ((start || continuous) && ready) begin
                    n.st = ST_REQ;
                end
            end
            ST_REQ: begin
                // R2: nothing toggles before the grant
                if (bus_gnt) begin
                    n.st    = ST_CONV;
                    n.phase = 1'b0;
                    strobe  = 1'b1;
                end
            end
            ST_CONV: begin
                // R3: strobe lasts two half periods with the clock low
                if (half_done) begin
                    if (q.phase) begin
                        n.st      = ST_SHIFT;
                        n.phase   = 1'b0;
                        n.bit_idx = '0;
                    end else begin
                        n.phase = 1'b1;
                    end
                end
            end
            ST_SHIFT: begin
                if (half_done) begin
                    if (!q.sclk) begin
                        n.sclk = 1'b1;
                        cap    = 1'b1;
                    end else begin
                        n.sclk = 1'b0;
                        if (q.bit_idx == BIT_W'(FRAME_BITS - 1)) begin
                            n.st      = ST_IDLE;
                            commit    = 1'b1;
                            // R6: the stale first frame is dropped
                            n.discard = 1'b0;
                            n.valid   = !q.discard;
                        end else begin
                            n.bit_idx = q.bit_idx + 1'b1;
                        end
                    end
                end
            end
            default: n.st = ST_IDLE;
        endcase
        commit_en = commit && !q.discard;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.st      <= ST_IDLE;
            q.phase   <= 1'b0;
            q.sclk    <= 1'b0;
            q.bit_idx <= '0;
            q.discard <= 1'b1;
            q.valid   <= 1'b0;
        end else begin
            q <= n;
        end
    end

    adc_frame_shifter #(
        .DATA_W    (DATA_W),
        .OUT_W     (OUT_W),
        .IDLE_BITS (IDLE_BITS),
        .BIT_W     (BIT_W)
    ) u_shift (
        .clk     (clk),
        .rst     (rst),
        .cap     (cap),
        .bit_idx (q.bit_idx),
        .sdo     (sdo),
        .commit  (commit_en),
        .words   (words)
    );

    assign bus_req = (q.st != ST_IDLE);
    assign conv    = (q.st == ST_CONV);
    assign sclk    = q.sclk;
    assign valid   = q.valid;
    assign ch0     = words[0];
    assign ch1     = words[1];
endmodule

// File: rtl/adc_capture_checker.sv
module adc_capture_checker #(
    parameter int PER_W      = 16,
    parameter int OUT_W      = 16,
    parameter int MIN_PERIOD = 134
) (
    input logic             clk,
    input logic             rst,
    input logic [PER_W-1:0] period,
    input logic             bus_gnt,
    input logic             bus_req,
    input logic             sclk,
    input logic             conv,
    input logic [OUT_W-1:0] ch0,
    input logic [OUT_W-1:0] ch1,
    input logic             valid
);
    localparam logic [PER_W-1:0] FLOOR = PER_W'(MIN_PERIOD);

    logic             conv_d1, seen_q, rise;
    logic [PER_W-1:0] gap_q, eff;

    assign rise = conv && !conv_d1;
    assign eff  = (period < FLOOR) ? FLOOR : period;

    always_ff @(posedge clk) begin
        if (rst) begin
            conv_d1 <= 1'b0;
            seen_q  <= 1'b0;
            gap_q   <= '0;
        end else begin
            conv_d1 <= conv;
            if (rise) begin
                gap_q  <= PER_W'(1);
                seen_q <= 1'b1;
            end else if (gap_q != '1) begin
                gap_q <= gap_q + 1'b1;
            end
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!sclk && !conv && !bus_req && !valid));

    // R2
    sclk_after_grant_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sclk) |-> $past(bus_gnt));

    // R3
    conv_sclk_excl_chk: assert property (@(posedge clk) disable iff (rst)
        conv |-> !sclk);

    // R3
    release_low_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_req) |-> !sclk);

    // R7
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid);

    // R7
    valid_at_release_chk: assert property (@(posedge clk) disable iff (rst)
        valid |-> !bus_req);

    // R7
    words_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!valid && !$past(rst)) |-> ($stable(ch0) && $stable(ch1)));

    // R8
    strobe_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (rise && seen_q) |-> (gap_q >= eff));
endmodule

bind dual_adc_capture adc_capture_checker #(
    .PER_W      (PER_W),
    .OUT_W      (OUT_W),
    .MIN_PERIOD (MIN_PERIOD)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .period  (period),
    .bus_gnt (bus_gnt),
    .bus_req (bus_req),
    .sclk    (sclk),
    .conv    (conv),
    .ch0     (ch0),
    .ch1     (ch1),
    .valid   (valid)
);

// File: tb/tb_dual_adc_capture.sv
`timescale 1ns/1ps
module tb_dual_adc_capture;
    localparam int CLK_DIV = 4;
    localparam int FRAME   = 34;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        continuous = 1'b0;
    logic [15:0] period = 16'd0;
    logic        gnt_en = 1'b1;
    logic        bus_gnt;
    logic        sdo = 1'b0;
    logic        bus_req, sclk, conv, valid;
    logic [15:0] ch0, ch1;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;

    // converter model state
    logic [13:0] ana0 = '0, ana1 = '0;
    logic [13:0] held0 = 14'h1555, held1 = 14'h2AAA;
    logic [13:0] out0 = '0, out1 = '0;
    logic        idle_fill = 1'b1;
    int          k = 0;

    assign bus_gnt = bus_req & gnt_en;

    dual_adc_capture #(
        .MAX_RATE_HZ (1_000_000),
        .CLK_DIV     (CLK_DIV)
    ) dut (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .continuous (continuous),
        .period     (period),
        .bus_gnt    (bus_gnt),
        .sdo        (sdo),
        .bus_req    (bus_req),
        .sclk       (sclk),
        .conv       (conv),
        .ch0        (ch0),
        .ch1        (ch1),
        .valid      (valid)
    );

    initial forever #2.5 clk = ~clk;

    function automatic logic fbit(input int idx);
        if (idx >= 2 && idx <= 15)  return out0[15 - idx];
        if (idx >= 18 && idx <= 31) return out1[31 - idx];
        return idle_fill;
    endfunction

    function automatic logic [15:0] sext(input logic [13:0] v);
        return {{2{v[13]}}, v};
    endfunction

    // converter: a strobe samples both inputs, the frame returns the prior pair
    initial forever begin
        @(posedge conv);
        out0 = held0; out1 = held1;
        held0 = ana0; held1 = ana1;
        k = 0;
    end
    initial forever begin
        @(negedge conv);
        sdo = fbit(0);
    end
    initial forever begin
        @(negedge sclk);
        k = k + 1;
        sdo = fbit(k);
    end

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial forever begin
        @(posedge clk);
        cyc = cyc + 1;
        if (cyc >= 150000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp = n_cmp + 1;
        if (act !== exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic request_one;
        @(negedge clk);
        start = 1'b1;
        do @(negedge clk); while (!bus_req);
        start = 1'b0;
    endtask

    task automatic observe_frame(output int stamp, output int conv_w,
                                 output int rises, output int vcount,
                                 output logic v_end, output logic v_after,
                                 output logic [15:0] o0, output logic [15:0] o1);
        logic prev;
        conv_w = 0; rises = 0; vcount = 0;
        do @(negedge clk); while (!conv);
        stamp = cyc;
        while (conv) begin
            conv_w = conv_w + 1;
            if (valid) vcount = vcount + 1;
            @(negedge clk);
        end
        prev = sclk;
        while (bus_req) begin
            if (sclk && !prev) rises = rises + 1;
            prev = sclk;
            if (valid) vcount = vcount + 1;
            @(negedge clk);
        end
        v_end = valid; o0 = ch0; o1 = ch1;
        if (valid) vcount = vcount + 1;
        @(negedge clk);
        v_after = valid;
        if (valid) vcount = vcount + 1;
    endtask

    task automatic t_reset;
        repeat (4) @(negedge clk);
        chk("R1", "bus_req", bus_req, 0);
        chk("R1", "conv", conv, 0);
        chk("R1", "sclk", sclk, 0);
        chk("R1", "valid", valid, 0);
        chk("R1", "ch0", ch0, 0);
        chk("R1", "ch1", ch1, 0);
        rst = 1'b0;
    endtask

    task automatic t_grant_and_first_frame;
        int st, cw, rs, vc; logic ve, va; logic [15:0] o0, o1;
        gnt_en = 1'b0;
        ana0 = 14'd5000; ana1 = 14'h3FFD;
        request_one();
        repeat (20) @(negedge clk);
        chk("R2", "bus_req while waiting", bus_req, 1);
        chk("R2", "conv before grant", conv, 0);
        chk("R2", "sclk before grant", sclk, 0);
        gnt_en = 1'b1;
        observe_frame(st, cw, rs, vc, ve, va, o0, o1);
        chk("R3", "strobe width", cw, CLK_DIV);
        chk("R3", "sclk pulses", rs, FRAME);
        chk("R6", "valid in first frame", vc, 0);
        chk("R6", "ch0 after first frame", o0, 0);
        chk("R6", "ch1 after first frame", o1, 0);
    endtask

    task automatic t_mixed_signs;
        int st, cw, rs, vc; logic ve, va; logic [15:0] o0, o1;
        idle_fill = 1'b1;
        ana0 = 14'h2000; ana1 = 14'h1FFF;
        request_one();
        observe_frame(st, cw, rs, vc, ve, va, o0, o1);
        chk("R7", "valid at release", ve, 1);
        chk("R7", "valid width", va, 0);
        chk("R7", "valid count", vc, 1);
        chk("R4", "ch0 positive", o0, 16'd5000);
        chk("R5", "ch1 negative extended", o1, 16'hFFFD);
        repeat (300) @(negedge clk);
        chk("R7", "ch0 held", ch0, 16'd5000);
        chk("R7", "ch1 held", ch1, 16'hFFFD);
        chk("R9", "single start gives one frame", bus_req, 0);
    endtask

    task automatic t_extremes;
        int st, cw, rs, vc; logic ve, va; logic [15:0] o0, o1;
        idle_fill = 1'b0;
        ana0 = 14'd1; ana1 = 14'h3FFF;
        request_one();
        observe_frame(st, cw, rs, vc, ve, va, o0, o1);
        chk("R5", "ch0 most negative", o0, 16'hE000);
        chk("R5", "ch1 most positive", o1, 16'h1FFF);
        chk("R4", "idle zeros ignored valid", ve, 1);
    endtask

    task automatic t_continuous;
        int s1, s2, s3, s4, cw, rs, vc; logic ve, va; logic [15:0] o0, o1;
        idle_fill = 1'b1;
        ana0 = 14'd123; ana1 = 14'h3E38;
        period = 16'd50;
        continuous = 1'b1;
        observe_frame(s1, cw, rs, vc, ve, va, o0, o1);
        chk("R4", "cont ch0 from prior strobe", o0, sext(out0));
        chk("R4", "cont ch1 from prior strobe", o1, sext(out1));
        observe_frame(s2, cw, rs, vc, ve, va, o0, o1);
        chk("R8", "spacing clamped to floor", s2 - s1, 200);
        chk("R7", "cont valid one cycle", vc, 1);
        chk("R4", "cont ch0 steady", o0, 16'd123);
        chk("R4", "cont ch1 steady", o1, 16'hFE38);
        period = 16'd300;
        observe_frame(s3, cw, rs, vc, ve, va, o0, o1);
        observe_frame(s4, cw, rs, vc, ve, va, o0, o1);
        chk("R8", "spacing follows period", s4 - s3, 300);
        continuous = 1'b0;
        repeat (500) @(negedge clk);
        chk("R9", "clearing continuous stops frames", bus_req, 0);
    endtask

    task automatic t_reset_mid_frame;
        int st, cw, rs, vc; logic ve, va; logic [15:0] o0, o1;
        ana0 = 14'd777; ana1 = 14'd42;
        request_one();
        repeat (60) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1", "sclk after mid reset", sclk, 0);
        chk("R1", "bus_req after mid reset", bus_req, 0);
        chk("R1", "ch0 cleared", ch0, 0);
        request_one();
        observe_frame(st, cw, rs, vc, ve, va, o0, o1);
        chk("R6", "no valid after mid reset", vc, 0);
        chk("R6", "words stay zero", o0, 0);
        ana0 = 14'd9; ana1 = 14'h3FF0;
        request_one();
        observe_frame(st, cw, rs, vc, ve, va, o0, o1);
        chk("R6", "second frame valid", ve, 1);
        chk("R6", "ch0 latency one sample", o0, 16'd777);
        chk("R6", "ch1 latency one sample", o1, 16'd42);
    endtask

    initial begin
        t_reset();
        t_grant_and_first_frame();
        t_mixed_signs();
        t_extremes();
        t_continuous();
        t_reset_mid_frame();
        repeat (10) @(negedge clk);
        summary();
        $finish;
    end
endmodule